// File: doc/BRIEF.md
# SPI Serial EEPROM Target Model

This block is a synthesizable SPI target that behaves like a small byte-addressable serial EEPROM. It is meant to sit opposite a host-side SPI controller in a verification setup. The host drives chip select, serial clock and MOSI in SPI mode 0, where both sides sample on the rising clock edge and change data on the falling edge. The model decodes an instruction byte, collects address bytes, and either streams out memory or status bytes on MISO or collects bytes to program into its array. All SPI inputs are synchronised into the system clock domain, so the serial clock must run several times slower than the system clock.

Programming goes through a write enable latch. Data bytes are gathered into a one-page buffer and are committed to the array only when chip select rises on a byte boundary. The commit starts a timed busy window, counted in system clocks, that stands in for the millisecond-scale internal write. While that window runs, only the status read is served. The memory size, page size and number of address bytes are parameters. An optional mode carries address bit 8 in bit 3 of the instruction byte, for parts with a 512-byte array and a single address byte.

Top module: `spi_eeprom_model`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Instruction 0x06 sets status bit 1, the write enable latch, when chip select rises after it. Instruction 0x04 clears that bit the same way. Read status (0x05) shifts out the current status byte and repeats it for every further byte clocked.
- R3: A write instruction (0x02) issued while the latch is clear is ignored. The array is unchanged and no busy window starts.
- R4: With the latch set, a write instruction, its address and one or more data bytes commit the data when chip select rises. Status bit 0, write-in-progress, then reads 1 for WRITE_CYCLES system clocks. After that, bits 0 and 1 both read 0.
- R5: A read (0x03) returns bytes from consecutive addresses for as long as the clock runs. It crosses page boundaries and wraps from the last address to address 0.
- R6: Write data that runs past the end of a page wraps to the start of the same page and never reaches the next page.
- R7: If chip select rises part way through a data byte, nothing is written, no busy window starts and the latch keeps its value.
- R8: While write-in-progress is set, every instruction other than read status is ignored and MISO stays 0.
- R9: With A8_IN_OPCODE set, bit 3 of a read or write instruction byte supplies address bit 8 and a single address byte follows, so 0x0B and 0x0A reach the upper 256 bytes.
- R10: Write status (0x01), when the latch is set, stores bits 7, 3 and 2 of its data byte and starts the same busy window. The other status bits read back from live state. With the latch clear, the instruction is ignored.
- R11: MISO is 0 while chip select is high. In a read, each data bit is valid before the rising clock edge on which the host samples it, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low (mode 0) |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when not selected |

## Verification
A wrong latch or busy state shows on the very next status read: a stuck write-in-progress bit keeps polling from ever finishing, and a latch that fails to clear lets a later unguarded write succeed. A bad commit or address path shows at the ports only when the affected bytes are read back. That can be one instruction later, so every write is followed by a read that spans its page edges, the neighbouring page and the address wrap. Gating faults under busy show as non-zero MISO bytes during an ignored read, or as a changed byte after the window ends.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

   localparam logic [7:0] CMD_STAT_WR   = 8'h01;
   localparam logic [7:0] CMD_PROG      = 8'h02;
   localparam logic [7:0] CMD_FETCH     = 8'h03;
   localparam logic [7:0] CMD_LATCH_OFF = 8'h04;
   localparam logic [7:0] CMD_STAT_RD   = 8'h05;
   localparam logic [7:0] CMD_LATCH_ON  = 8'h06;

   // position of address bit 8 inside the instruction byte
   localparam int A8_POS = 3;

   typedef enum logic [2:0] {
      PH_OPCODE,
      PH_ADDR,
      PH_FETCH,
      PH_PROG,
      PH_STAT_RD,
      PH_STAT_WR,
      PH_HOLD
   } phase_t;

   typedef enum logic [2:0] {
      K_NONE,
      K_FETCH,
      K_PROG,
      K_STWR,
      K_LON,
      K_LOFF
   } kind_t;

endpackage

// File: rtl/spi_eep_frontend.sv
module spi_eep_frontend #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       csn,
   input  logic       sck,
   input  logic       mosi,
   output logic       sel,
   output logic       sck_rise,
   output logic       sck_fall,
   output logic       cs_end,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic [2:0] bit_idx
);

   logic [SYNC_STAGES-1:0] csn_p, sck_p, mosi_p;
   logic csn_s, sck_s, mosi_s, csn_d, sck_d;
   logic [6:0] rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csn_p  <= '1;
         sck_p  <= '0;
         mosi_p <= '0;
         csn_d  <= 1'b1;
         sck_d  <= 1'b0;
      end else begin
         csn_p  <= {csn_p[SYNC_STAGES-2:0], csn};
         sck_p  <= {sck_p[SYNC_STAGES-2:0], sck};
         mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
         csn_d  <= csn_s;
         sck_d  <= sck_s;
      end
   end

   assign csn_s    = csn_p[SYNC_STAGES-1];
   assign sck_s    = sck_p[SYNC_STAGES-1];
   assign mosi_s   = mosi_p[SYNC_STAGES-1];
   assign sel      = ~csn_s;
   assign sck_rise = sel & sck_s & ~sck_d;
   assign sck_fall = sel & ~sck_s & sck_d;
   assign cs_end   = csn_s & ~csn_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= '0;
         rx_sh   <= '0;
      end else if (!sel) begin
         bit_idx <= '0;
      end else if (sck_rise) begin
         bit_idx <= bit_idx + 3'd1;
         rx_sh   <= {rx_sh[5:0], mosi_s};
      end
   end

   assign byte_done = sck_rise && (bit_idx == 3'd7);
   assign rx_byte   = {rx_sh, mosi_s};

endmodule

// File: rtl/spi_eep_pagebuf.sv
module spi_eep_pagebuf #(
   parameter int PAGE_BYTES = 16,
   localparam int OFF_W = $clog2(PAGE_BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       wr,
   input  logic [OFF_W-1:0]           idx,
   input  logic [7:0]                 wdata,
   output logic [PAGE_BYTES-1:0][7:0] data,
   output logic [PAGE_BYTES-1:0]      mask
);

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data[g] <= '0;
            mask[g] <= 1'b0;
         end else if (clr) begin
            mask[g] <= 1'b0;
         end else if (wr && (idx == OFF_W'(g))) begin
            data[g] <= wdata;
            mask[g] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/spi_eep_array.sv
module spi_eep_array #(
   parameter int MEM_BYTES  = 512,
   parameter int PAGE_BYTES = 16,
   localparam int ADDR_W = $clog2(MEM_BYTES),
   localparam int OFF_W  = $clog2(PAGE_BYTES),
   localparam int PG_W   = ADDR_W - OFF_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          raddr,
   output logic [7:0]                 rdata,
   input  logic                       commit,
   input  logic [PG_W-1:0]            page_sel,
   input  logic [PAGE_BYTES-1:0][7:0] pdata,
   input  logic [PAGE_BYTES-1:0]      pmask
);

   logic [7:0] mem [MEM_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      end else if (commit) begin
         for (int k = 0; k < PAGE_BYTES; k++) begin
            if (pmask[k]) mem[{page_sel, OFF_W'(k)}] <= pdata[k];
         end
      end
   end

   assign rdata = mem[raddr];

   AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (pmask != '0)); // R7

endmodule

// File: rtl/spi_eep_busy.sv
module spi_eep_busy #(
   parameter int WRITE_CYCLES = 1500,
   localparam int CW = $clog2(WRITE_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (start)        cnt <= CW'(WRITE_CYCLES);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));

endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model #(
   parameter int MEM_BYTES    = 512,
   parameter int PAGE_BYTES   = 16,
   parameter int ADDR_BYTES   = 1,
   parameter bit A8_IN_OPCODE = 1'b1,
   parameter int WRITE_CYCLES = 1500,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_csn,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso
);
   import spi_eep_pkg::*;

   localparam int ADDR_W = $clog2(MEM_BYTES);
   localparam int OFF_W  = $clog2(PAGE_BYTES);
   localparam int PG_W   = ADDR_W - OFF_W;
   localparam int ACC_W  = ADDR_BYTES * 8;
   localparam int CNT_W  = $clog2(ADDR_BYTES + 1);

   initial begin
      assert (MEM_BYTES == (1 << ADDR_W)) else $error("MEM_BYTES must be a power of two");
      assert (PAGE_BYTES == (1 << OFF_W) && PAGE_BYTES >= 2) else $error("PAGE_BYTES must be a power of two");
      assert (MEM_BYTES > PAGE_BYTES) else $error("array must hold more than one page");
      assert (ADDR_BYTES >= 1 && ADDR_BYTES <= 3) else $error("ADDR_BYTES out of range");
      assert (ADDR_W <= ACC_W + int'(A8_IN_OPCODE)) else $error("address bytes too short");
      assert (!A8_IN_OPCODE || ADDR_BYTES == 1) else $error("bit-8 mode needs one address byte");
      assert (WRITE_CYCLES >= 2) else $error("WRITE_CYCLES too small");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES too small");
   end

   logic       sel, sck_rise, sck_fall, cs_end, byte_done;
   logic [7:0] rx_byte;
   logic [2:0] bit_idx;

   spi_eep_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_fe (
      .clk(clk), .rst_n(rst_n), .csn(spi_csn), .sck(spi_sck), .mosi(spi_mosi),
      .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_end(cs_end),
      .byte_done(byte_done), .rx_byte(rx_byte), .bit_idx(bit_idx)
   );

   phase_t            phase;
   kind_t             kind;
   logic [ADDR_W-1:0] addr, addr_new, raddr;
   logic [CNT_W-1:0]  abyte_cnt;
   logic              got_data, wel, a8_q, miso_q;
   logic [2:0]        sr_keep;
   logic [7:0]        sr_pending, tx_byte, op_c, status_byte, rdata;
   logic [ACC_W-1:0]  acc_next;
   logic              busy, done, commit, sr_commit, pb_clr, pb_wr, aligned;
   logic [PAGE_BYTES-1:0][7:0] pb_data;
   logic [PAGE_BYTES-1:0]      pb_mask;

   // address assembly: one variant per address byte count
   if (ADDR_BYTES == 1) begin : g_acc1
      assign acc_next = rx_byte;
   end else begin : g_accn
      logic [ACC_W-9:0] acc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             acc_q <= '0;
         else if (phase == PH_OPCODE && byte_done) acc_q <= '0;
         else if (phase == PH_ADDR && byte_done)   acc_q <= acc_next[ACC_W-9:0];
      end
      assign acc_next = {acc_q, rx_byte};
   end

   // optional address bit 8 carried in the instruction byte
   if (A8_IN_OPCODE) begin : g_a8
      assign op_c     = rx_byte & ~(8'd1 << A8_POS);
      assign addr_new = ADDR_W'({a8_q, acc_next});
   end else begin : g_plain
      assign op_c     = rx_byte;
      assign addr_new = ADDR_W'({1'b0 & a8_q, acc_next});
   end

   assign status_byte = {sr_keep[2], 3'b000, sr_keep[1:0], wel, busy};
   assign aligned     = (bit_idx == 3'd0);
   assign raddr       = (phase == PH_ADDR) ? addr_new : addr;
   assign pb_clr      = byte_done && (phase == PH_OPCODE);
   assign pb_wr       = byte_done && (phase == PH_PROG);
   assign commit      = cs_end && aligned && (kind == K_PROG) && got_data;
   assign sr_commit   = cs_end && aligned && (kind == K_STWR) && got_data;

   spi_eep_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_pb (
      .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr(pb_wr),
      .idx(addr[OFF_W-1:0]), .wdata(rx_byte), .data(pb_data), .mask(pb_mask)
   );

   spi_eep_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_arr (
      .clk(clk), .rst_n(rst_n), .raddr(raddr), .rdata(rdata),
      .commit(commit), .page_sel(addr[ADDR_W-1:OFF_W]),
      .pdata(pb_data), .pmask(pb_mask)
   );

   spi_eep_busy #(.WRITE_CYCLES(WRITE_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(commit | sr_commit), .busy(busy), .done(done)
   );

   // transaction sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_OPCODE;
         kind       <= K_NONE;
         addr       <= '0;
         abyte_cnt  <= '0;
         got_data   <= 1'b0;
         a8_q       <= 1'b0;
         tx_byte    <= '0;
         sr_pending <= '0;
      end else begin
         if (byte_done) begin
            case (phase)
               PH_OPCODE: begin
                  abyte_cnt <= '0;
                  got_data  <= 1'b0;
                  a8_q      <= rx_byte[A8_POS];
                  phase     <= PH_HOLD;
                  kind      <= K_NONE;
                  if (!busy || op_c == CMD_STAT_RD) begin
                     case (op_c)
                        CMD_FETCH: begin
                           phase <= PH_ADDR;
                           kind  <= K_FETCH;
                        end
                        CMD_PROG: if (wel) begin
                           phase <= PH_ADDR;
                           kind  <= K_PROG;
                        end
                        CMD_STAT_RD: begin
                           phase   <= PH_STAT_RD;
                           tx_byte <= status_byte;
                        end
                        CMD_STAT_WR: if (wel) begin
                           phase <= PH_STAT_WR;
                           kind  <= K_STWR;
                        end
                        CMD_LATCH_ON:  kind <= K_LON;
                        CMD_LATCH_OFF: kind <= K_LOFF;
                        default: ;
                     endcase
                  end
               end
               PH_ADDR: begin
                  if (abyte_cnt == CNT_W'(ADDR_BYTES - 1)) begin
                     if (kind == K_FETCH) begin
                        tx_byte <= rdata;
                        addr    <= addr_new + 1'b1;
                        phase   <= PH_FETCH;
                     end else begin
                        addr    <= addr_new;
                        phase   <= PH_PROG;
                     end
                  end else begin
                     abyte_cnt <= abyte_cnt + 1'b1;
                  end
               end
               PH_FETCH: begin
                  tx_byte <= rdata;
                  addr    <= addr + 1'b1;
               end
               PH_PROG: begin
                  got_data <= 1'b1;
                  addr     <= {addr[ADDR_W-1:OFF_W], addr[OFF_W-1:0] + 1'b1};
               end
               PH_STAT_RD: tx_byte <= status_byte;
               PH_STAT_WR: begin
                  got_data   <= 1'b1;
                  sr_pending <= rx_byte;
               end
               default: ;
            endcase
         end
         if (!sel) begin
            phase <= PH_OPCODE;
            kind  <= K_NONE;
         end
      end
   end

   // latch and stored status bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel     <= 1'b0;
         sr_keep <= '0;
      end else begin
         if (sr_commit) sr_keep <= {sr_pending[7], sr_pending[3], sr_pending[2]};
         if (done)
            wel <= 1'b0;
         else if (cs_end && aligned && kind == K_LON)
            wel <= 1'b1;
         else if (cs_end && aligned && kind == K_LOFF)
            wel <= 1'b0;
      end
   end

   // mode 0 output: new bit after each falling edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         miso_q <= 1'b0;
      else if (!sel)
         miso_q <= 1'b0;
      else if (sck_fall)
         miso_q <= (phase == PH_FETCH || phase == PH_STAT_RD) ? tx_byte[3'd7 - bit_idx] : 1'b0;
   end

   assign spi_miso = miso_q;

   AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (commit || sr_commit) |-> !busy); // R8
   AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (commit || sr_commit) |=> busy); // R4
   AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !wel); // R4
   AST_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && $past(!sel)) |-> !spi_miso); // R11

endmodule

// File: tb/spi_eeprom_model_test.sv
module spi_eeprom_model_test;

   localparam int WCYC = 1500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csn = 1'b1, sck = 1'b0, mosi = 1'b0;
   logic miso;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q[$];
   logic [7:0] act_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   spi_eeprom_model #(
      .MEM_BYTES(512), .PAGE_BYTES(16), .ADDR_BYTES(1),
      .A8_IN_OPCODE(1'b1), .WRITE_CYCLES(WCYC), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck),
      .spi_mosi(mosi), .spi_miso(miso)
   );

   // scoreboard monitor
   always @(negedge clk) begin
      while (act_q.size() > 0 && exp_q.size() > 0) begin
         logic [7:0] a, e;
         string t;
         a = act_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", t, a, e);
         end
      end
   end

   task automatic push(input logic [7:0] e, input logic [7:0] a, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      act_q.push_back(a);
   endtask

   task automatic bit_x(input logic b, output logic r);
      mosi = b;
      repeat (8) @(negedge clk);
      r = miso;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         logic r;
         bit_x(tx[i], r);
         rx[i] = r;
      end
   endtask

   task automatic cs_on();
      @(negedge clk);
      csn = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic cs_off();
      repeat (8) @(negedge clk);
      csn = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] tx);
      logic [7:0] d;
      byte_x(tx, d);
   endtask

   task automatic expect_rx(input logic [7:0] e, input string t);
      logic [7:0] d;
      byte_x(8'hFF, d);
      push(e, d, t);
   endtask

   task automatic one_op(input logic [7:0] op);
      cs_on(); send(op); cs_off();
   endtask

   task automatic stat_check(input logic [7:0] e, input string t);
      cs_on(); send(8'h05); expect_rx(e, t); cs_off();
   endtask

   task automatic read_check(input logic [7:0] op, input logic [7:0] a,
                             input logic [7:0] e, input string t);
      cs_on(); send(op); send(a); expect_rx(e, t); cs_off();
   endtask

   task automatic poll_idle(input string t);
      logic [7:0] s;
      bit ok = 1'b0;
      for (int n = 0; n < 60; n++) begin
         cs_on(); send(8'h05); byte_x(8'hFF, s); cs_off();
         if (!s[0]) begin
            ok = 1'b1;
            break;
         end
      end
      push(8'h01, {7'd0, ok}, t);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // R11 idle output, R1 reset state
      push(8'h00, {7'd0, miso}, "R11 miso idle");
      stat_check(8'h00, "R1 status after reset");
      read_check(8'h03, 8'h00, 8'hFF, "R1 array after reset");

      // R3 write without latch
      cs_on(); send(8'h02); send(8'h05); send(8'h12); cs_off();
      stat_check(8'h00, "R3 no busy without latch");
      read_check(8'h03, 8'h05, 8'hFF, "R3 byte unchanged");

      // R2 latch set and clear, repeated status
      one_op(8'h06);
      cs_on(); send(8'h05);
      expect_rx(8'h02, "R2 latch set");
      expect_rx(8'h02, "R2 status repeats");
      cs_off();
      one_op(8'h04);
      stat_check(8'h00, "R2 latch cleared");

      // R4 program three bytes
      one_op(8'h06);
      cs_on(); send(8'h02); send(8'h10); send(8'hA1); send(8'hA2); send(8'hA3); cs_off();
      stat_check(8'h03, "R4 busy with latch");
      // R8 read and write ignored while busy
      read_check(8'h03, 8'h10, 8'h00, "R8 read ignored while busy");
      cs_on(); send(8'h02); send(8'h60); send(8'h99); cs_off();
      poll_idle("R4 busy ends");
      stat_check(8'h00, "R4 latch cleared after cycle");
      cs_on(); send(8'h03); send(8'h10);
      expect_rx(8'hA1, "R5 seq 0");
      expect_rx(8'hA2, "R5 seq 1");
      expect_rx(8'hA3, "R5 seq 2");
      expect_rx(8'hFF, "R5 seq 3");
      cs_off();
      read_check(8'h03, 8'h60, 8'hFF, "R8 busy write dropped");

      // R6 page wrap on program
      one_op(8'h06);
      cs_on(); send(8'h02); send(8'h2E); send(8'h11); send(8'h22); send(8'h33); cs_off();
      poll_idle("R6 busy ends");
      cs_on(); send(8'h03); send(8'h2E);
      expect_rx(8'h11, "R6 byte 2E");
      expect_rx(8'h22, "R6 byte 2F");
      expect_rx(8'hFF, "R6 next page untouched");
      cs_off();
      read_check(8'h03, 8'h20, 8'h33, "R6 wrapped to page start");

      // R9 address bit 8 in instruction, R5 wrap at end of array
      one_op(8'h06);
      cs_on(); send(8'h0A); send(8'hFF); send(8'h5A); cs_off();
      poll_idle("R9 busy ends");
      cs_on(); send(8'h0B); send(8'hFF);
      expect_rx(8'h5A, "R9 upper byte");
      expect_rx(8'hFF, "R5 wrap to zero");
      cs_off();
      read_check(8'h03, 8'hFF, 8'hFF, "R9 lower half untouched");

      // R7 partial byte abort
      one_op(8'h06);
      cs_on(); send(8'h02); send(8'h40); send(8'h77);
      for (int i = 0; i < 4; i++) begin
         logic r;
         bit_x(1'b1, r);
      end
      cs_off();
      stat_check(8'h02, "R7 no busy, latch kept");
      read_check(8'h03, 8'h40, 8'hFF, "R7 byte not written");

      // R10 status write
      cs_on(); send(8'h01); send(8'hFF); cs_off();
      stat_check(8'h8F, "R10 stored bits with busy");
      poll_idle("R10 busy ends");
      stat_check(8'h8C, "R10 writable bits only");
      cs_on(); send(8'h01); send(8'h00); cs_off();
      stat_check(8'h8C, "R10 ignored without latch");

      repeat (20) @(negedge clk);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule